// File: doc/BRIEF.md
# Comparator Interrupt and Status Logic

This block is the clocked wrapper placed around an analog voltage comparator. The comparator's decision arrives as a raw, asynchronous bit that is high when the positive input is above the negative input. A flop chain brings that bit into the clock domain. The result can be read as a status bit. An edge detector watches the synchronised value and reports edges of the kind that a two-bit mode field selects.

A matching edge sets a sticky flag. The flag stays set until software writes a one to it or the interrupt controller acknowledges the vector. An interrupt request is raised while the flag is set, provided both the local enable bit and the global enable input are high. The block also drives the analog side. It outputs a power-down control, a select that swaps the positive pin for an internal fixed reference, and a select that routes the converter's multiplexer to the negative input. That last route is used only while the converter is switched off.

Software reaches the block through a small register port with two addresses. Address 0 is the control/status register. Address 1 holds the negative-input routing enable in bit 0.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: The status bit at address 0, bit 5 shows the raw comparator input after two rising clock edges. With the raw input low it reads 0 after reset. It is not changed by writes.
- R2: The mode field at address 0, bits 1:0 selects the edge that sets the flag at address 0, bit 4. Code 00 selects any change of the synchronised bit, 10 selects a 1-to-0 change and 11 selects a 0-to-1 change. The flag is set on the third rising edge after the raw input changes, and a newly written mode applies from the next clock.
- R3: With mode code 01, no change of the comparator ever sets the flag.
- R4: Writing address 0 with bit 4 at one clears the flag. Writing it with bit 4 at zero leaves the flag unchanged.
- R5: A one-cycle pulse on `irq_ack_i` clears the flag.
- R6: If an edge event and a clear from a write or an acknowledge fall on the same clock edge, the flag ends up set.
- R7: `irq_o` is high exactly when the flag, the enable bit (address 0, bit 3) and `gie_i` are all high.
- R8: Address 0, bit 7 disables the comparator. While it is set, `pwr_down_o` is high, the synchronised status bit holds its value and no event is produced.
- R9: Address 0, bit 6 drives `pos_sel_ref_o`. A value of 1 selects the internal reference for the positive input.
- R10: `neg_sel_mux_o` is high only when address 1, bit 0 is set and `adc_en_i` is low.
- R11: All writable bits reset to 0. Address 0, bit 2 and address 1, bits 7:1 always read 0. Writing 0xFF to address 0 with the status bit low reads back 0xCB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 1 | Raw comparator decision, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control/status, 1 routing |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_ack_i | input | 1 | Vector-taken pulse, clears the flag |
| gie_i | input | 1 | Global interrupt enable |
| adc_en_i | input | 1 | Converter enabled; blocks multiplexer routing |
| irq_o | output | 1 | Interrupt request |
| pwr_down_o | output | 1 | Comparator power-down control |
| pos_sel_ref_o | output | 1 | Positive input uses internal reference |
| neg_sel_mux_o | output | 1 | Negative input uses converter multiplexer |

## Verification
Two things can act on the flag in the same cycle: the hardware set from an edge event, and a clear from a write-one or an acknowledge. The bench provokes this by changing the raw input and then driving both clears during the cycle in which the event is live, which is the cycle between the second and third rising edges. It then judges that the flag reads one. Before and after that test, it clears the flag through each path alone and checks that the flag reads zero, so a set that survives the clear cannot pass unnoticed.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } edge_mode_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned BIT_DIS  = 7;
  localparam int unsigned BIT_REF  = 6;
  localparam int unsigned BIT_OUT  = 5;
  localparam int unsigned BIT_FLAG = 4;
  localparam int unsigned BIT_EN   = 3;
  localparam int unsigned BIT_MUX  = 0;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic hold_i,
  output logic sync_o
);

  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stg_q <= '0;
        else if (!hold_i) stg_q <= raw_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stg_q <= '0;
        else if (!hold_i) stg_q <= {stg_q[STAGES-2:0], raw_i};
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(sync_o));

endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  input  edge_mode_e mode_i,
  output logic       evt_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_TOGGLE: evt_o = sig_i ^ prev_q;
      MODE_FALL:   evt_o = prev_q & ~sig_i;
      MODE_RISE:   evt_o = ~prev_q & sig_i;
      default:     evt_o = 1'b0;
    endcase
  end

  // R2
  evt_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (sig_i != prev_q));

  // R3
  rsvd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RSVD) |-> !evt_o);

endmodule

// File: rtl/cmp_irq_flag.sv
module cmp_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  // set wins over clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R2 R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  // R4 R5
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);

  // R2
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_i) |=> !flag_o);

endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_raw_i,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             irq_ack_i,
  input  logic             gie_i,
  input  logic             adc_en_i,
  output logic             irq_o,
  output logic             pwr_down_o,
  output logic             pos_sel_ref_o,
  output logic             neg_sel_mux_o
);

  logic       dis_q, ref_q, en_q, mux_en_q;
  edge_mode_e mode_q;
  logic       sync_val, evt, flag, flag_clr;
  logic       wr_ctrl, wr_aux;
  logic       unused_wbits;

  assign wr_ctrl = wr_en_i & ~addr_i;
  assign wr_aux  = wr_en_i & addr_i;
  assign unused_wbits = ^{wdata_i[BIT_OUT], wdata_i[2], wdata_i[REG_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q  <= 1'b0;
      ref_q  <= 1'b0;
      en_q   <= 1'b0;
      mode_q <= MODE_TOGGLE;
    end else if (wr_ctrl) begin
      dis_q  <= wdata_i[BIT_DIS];
      ref_q  <= wdata_i[BIT_REF];
      en_q   <= wdata_i[BIT_EN];
      mode_q <= edge_mode_e'(wdata_i[1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mux_en_q <= 1'b0;
    else if (wr_aux) mux_en_q <= wdata_i[BIT_MUX];
  end

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (cmp_raw_i),
    .hold_i (dis_q),
    .sync_o (sync_val)
  );

  cmp_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sync_val),
    .mode_i (mode_q),
    .evt_o  (evt)
  );

  assign flag_clr = (wr_ctrl & wdata_i[BIT_FLAG]) | irq_ack_i;

  cmp_irq_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt),
    .clr_i  (flag_clr),
    .flag_o (flag)
  );

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[BIT_DIS]  = dis_q;
      rdata_o[BIT_REF]  = ref_q;
      rdata_o[BIT_OUT]  = sync_val;
      rdata_o[BIT_FLAG] = flag;
      rdata_o[BIT_EN]   = en_q;
      rdata_o[1:0]      = mode_q;
    end else begin
      rdata_o[BIT_MUX]  = mux_en_q;
    end
  end

  assign irq_o         = flag & en_q & gie_i;
  assign pwr_down_o    = dis_q;
  assign pos_sel_ref_o = ref_q;
  assign neg_sel_mux_o = mux_en_q & ~adc_en_i;

endmodule

// File: tb/cmp_irq_ctrl_bench.sv
module cmp_irq_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ack = 1'b0, gie = 1'b0, adc_en = 1'b0;
  logic       irq, pwr_dn, pos_ref, neg_mux;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_irq_ctrl u_cmp_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(raw), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_ack_i(ack),
    .gie_i(gie), .adc_en_i(adc_en), .irq_o(irq), .pwr_down_o(pwr_dn),
    .pos_sel_ref_o(pos_ref), .neg_sel_mux_o(neg_mux)
  );

  function automatic logic [7:0] mk(input logic dis, input logic rf, input logic en,
                                    input logic [1:0] md, input logic clr);
    return {dis, rf, 1'b0, clr, en, 1'b0, md};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic v;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    #1;
    // R11 R1 reset state
    chk("R11 reset ctrl", rdata, 8'h00);
    chk("R7 reset irq", {7'b0, irq}, 8'h00);
    chk("R8 reset pwr", {7'b0, pwr_dn}, 8'h00);
    chk("R10 reset mux", {7'b0, neg_mux}, 8'h00);
    addr = 1'b1; #1;
    chk("R11 reset aux", rdata, 8'h00);
    addr = 1'b0;

    // R11 R9 R8 read-back mask
    wr(1'b0, 8'hFF);
    #1;
    chk("R11 ff readback", rdata, 8'hCB);
    chk("R9 ref select", {7'b0, pos_ref}, 8'h01);
    chk("R8 pwr down", {7'b0, pwr_dn}, 8'h01);
    wr(1'b0, 8'h00);
    #1;
    chk("R9 ref clear", {7'b0, pos_ref}, 8'h00);

    // R10 routing
    wr(1'b1, 8'hFF);
    #1;
    addr = 1'b1; #1;
    chk("R11 aux readback", rdata, 8'h01);
    addr = 1'b0;
    adc_en = 1'b0; #1;
    chk("R10 mux adc off", {7'b0, neg_mux}, 8'h01);
    adc_en = 1'b1; #1;
    chk("R10 mux adc on", {7'b0, neg_mux}, 8'h00);
    wr(1'b1, 8'h00);
    adc_en = 1'b0; #1;
    chk("R10 mux disabled", {7'b0, neg_mux}, 8'h00);

    // R1 latency
    @(negedge clk); raw = 1'b1;
    @(negedge clk); #1;
    chk("R1 one edge", {7'b0, rdata[5]}, 8'h00);
    @(negedge clk); #1;
    chk("R1 two edges", {7'b0, rdata[5]}, 8'h01);

    // R2 R3 R7 sweep of modes and directions
    gie = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int init = 0; init < 2; init++) begin
        logic exp;
        wr(1'b0, mk(1'b0, 1'b0, 1'b1, 2'(m), 1'b0));
        raw = 1'(init);
        wait_n(4);
        wr(1'b0, mk(1'b0, 1'b0, 1'b1, 2'(m), 1'b1));
        raw = ~1'(init);
        wait_n(2); #1;
        chk("R2 flag not early", {7'b0, rdata[4]}, 8'h00);
        wait_n(1); #1;
        case (m)
          0: exp = 1'b1;
          1: exp = 1'b0;
          2: exp = (init == 1);
          default: exp = (init == 0);
        endcase
        chk(m == 1 ? "R3 reserved mode flag" : "R2 mode flag", {7'b0, rdata[4]}, {7'b0, exp});
        chk("R7 irq follows flag", {7'b0, irq}, {7'b0, exp});
      end
    end

    // R7 gating sweep with flag set
    wr(1'b0, mk(1'b0, 1'b0, 1'b1, 2'b00, 1'b1));
    raw = ~raw;
    wait_n(3);
    for (int g = 0; g < 4; g++) begin
      wr(1'b0, mk(1'b0, 1'b0, g[0], 2'b00, 1'b0));
      gie = g[1];
      #1;
      chk("R4 write zero keeps flag", {7'b0, rdata[4]}, 8'h01);
      chk("R7 irq gating", {7'b0, irq}, {7'b0, g[0] & g[1]});
    end

    // R4 write-one clear
    wr(1'b0, mk(1'b0, 1'b0, 1'b1, 2'b00, 1'b1));
    #1;
    chk("R4 write one clears", {7'b0, rdata[4]}, 8'h00);

    // R5 ack clear
    raw = ~raw;
    wait_n(3); #1;
    chk("R5 flag set before ack", {7'b0, rdata[4]}, 8'h01);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; #1;
    chk("R5 ack clears", {7'b0, rdata[4]}, 8'h00);

    // R6 set and both clears on the same edge
    @(negedge clk); raw = ~raw;
    wait_n(2);
    addr = 1'b0; wdata = mk(1'b0, 1'b0, 1'b1, 2'b00, 1'b1); wr_en = 1'b1; ack = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ack = 1'b0; #1;
    chk("R6 set beats clear", {7'b0, rdata[4]}, 8'h01);
    wr(1'b0, mk(1'b0, 1'b0, 1'b1, 2'b00, 1'b1));

    // R8 disable holds status, blocks events
    v = rdata[5];
    wr(1'b0, mk(1'b1, 1'b0, 1'b1, 2'b00, 1'b1));
    raw = ~v;
    wait_n(5); #1;
    chk("R8 status held", {7'b0, rdata[5]}, {7'b0, v});
    chk("R8 no event", {7'b0, rdata[4]}, 8'h00);
    chk("R8 pwr high", {7'b0, pwr_dn}, 8'h01);
    wr(1'b0, mk(1'b0, 1'b0, 1'b1, 2'b00, 1'b0));
    wait_n(3); #1;
    chk("R8 resumes", {7'b0, rdata[5]}, {7'b0, ~v});
    chk("R8 pwr low", {7'b0, pwr_dn}, 8'h00);

    finish_run();
  end

endmodule